// File: doc/BRIEF.md
# Timer compare interrupt flag unit

This block holds the interrupt sources of an 8-bit timer/counter. There are three sources: compare channel A, compare channel B and counter overflow. It owns the two compare registers and compares each of them with the incoming counter value on every cycle. It also latches the overflow strobe. Each event sets a sticky flag.

Software reaches four byte-wide registers through a simple bus port: the enable mask, the flags, and the two compare values. A flag can be cleared in two ways. Software can write a one to its bit, or the CPU can acknowledge the vector that belongs to it. A source requests an interrupt only when the global enable, its mask bit and its flag are all set. A fixed priority picks which pending source is reported on the vector index output.

Top module: `tmr_irq_unit`

## Requirements
- R1: When `count_i` equals a compare register in a cycle, the matching flag is set at the next clock edge. Channel A uses flag bit 1 and channel B uses flag bit 2. A bus write to a compare register first takes part in the comparison in the cycle after the write.
- R2: When `ovf_i` is high in a cycle, flag bit 0 is set at the next clock edge.
- R3: The registers are selected by `bus_addr_i`: 0 is the mask, 1 the flags, 2 compare A, 3 compare B. `bus_rdata_o` shows the selected register in the same cycle. For the mask and the flags, bits 7 to 3 always read as zero. The mask bit positions are the same as the flag bit positions.
- R4: A write to the flag register clears every flag whose data bit is 1. A flag whose data bit is 0 keeps its value.
- R5: A one-cycle `ack_i` clears only the flag selected by `ack_idx_i`. The encoding is 0 overflow, 1 compare A, 2 compare B. Code 3 clears nothing.
- R6: If a set event and a clear (write-one or acknowledge) reach the same flag in the same cycle, the flag ends up set.
- R7: `irq_o` is high exactly when `gie_i` is high and at least one source has both its flag and its mask bit set.
- R8: Among the pending sources, compare A has the highest priority, then compare B, then overflow. `irq_idx_o` gives the winner: 1 for A, 2 for B, 0 for overflow. It is 0 when nothing is pending.
- R9: After reset, the mask, the flags and both compare registers read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| count_i | input | 8 | Current counter value |
| ovf_i | input | 1 | Overflow strobe, one per event |
| gie_i | input | 1 | Global interrupt enable |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 2 | Register select |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data of the selected register |
| ack_i | input | 1 | Vector acknowledge pulse |
| ack_idx_i | input | 2 | Index of the acknowledged vector |
| irq_o | output | 1 | Interrupt request |
| irq_idx_o | output | 2 | Index of the highest-priority pending source |

## Verification
The assertions assume that the inputs are stable around the sampling edge, and that `ack_i` and `ovf_i` are sampled one cycle at a time with no implied hold. The stimulus drives every input on the falling edge and changes it only once per cycle. The counter value is random, but in about half of the cycles it is forced to one of the current compare values, so matches are frequent. Directed steps line up a set event with a write-one clear and with an acknowledge in the same cycle, issue the unused acknowledge code, and write a compare register and then match against it on the next cycle.

// File: rtl/tmr_irq_pkg.sv
package tmr_irq_pkg;
  localparam int unsigned NSRC   = 3;
  localparam int unsigned IDX_W  = 2;
  localparam int unsigned NCMP   = 2;
  localparam int unsigned SRC_OVF  = 0;
  localparam int unsigned SRC_CMPA = 1;
  localparam int unsigned SRC_CMPB = 2;
  typedef enum logic [1:0] {
    REG_MASK = 2'd0,
    REG_FLAG = 2'd1,
    REG_CMPA = 2'd2,
    REG_CMPB = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/tmr_cmp_bank.sv
module tmr_cmp_bank #(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned NCMP  = 2
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [CNT_W-1:0]           count_i,
  input  logic [NCMP-1:0]            wr_en_i,
  input  logic [CNT_W-1:0]           wdata_i,
  output logic [NCMP-1:0][CNT_W-1:0] cmp_o,
  output logic [NCMP-1:0]            match_o
);
  for (genvar c = 0; c < NCMP; c++) begin : g_ch
    logic [CNT_W-1:0] cmp_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         cmp_q <= '0;
      else if (wr_en_i[c]) cmp_q <= wdata_i;
    end
    assign cmp_o[c]   = cmp_q;
    assign match_o[c] = (count_i == cmp_q);

    // R1: a written value becomes the compare value at the next edge
    a_r1_cmp_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_en_i[c] |=> cmp_q == $past(wdata_i));
  end
endmodule

// File: rtl/tmr_flag_reg.sv
module tmr_flag_reg #(
  parameter int unsigned NSRC = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] set_i,
  input  logic [NSRC-1:0] wclr_i,
  input  logic [NSRC-1:0] aclr_i,
  output logic [NSRC-1:0] flag_o
);
  logic [NSRC-1:0] flag_q, flag_d;

  // set wins over either clear
  always_comb flag_d = set_i | (flag_q & ~wclr_i & ~aclr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= '0;
    else         flag_q <= flag_d;
  end
  assign flag_o = flag_q;

  for (genvar s = 0; s < NSRC; s++) begin : g_chk
    a_r6_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[s] |=> flag_q[s]);
    a_r4_w1c: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wclr_i[s] && !set_i[s]) |=> !flag_q[s]);
    a_r4_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_q[s] && !wclr_i[s] && !aclr_i[s]) |=> flag_q[s]);
    a_r5_ack_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (aclr_i[s] && !set_i[s]) |=> !flag_q[s]);
  end
endmodule

// File: rtl/tmr_irq_arb.sv
module tmr_irq_arb
  import tmr_irq_pkg::*;
(
  input  logic             gie_i,
  input  logic [NSRC-1:0]  flag_i,
  input  logic [NSRC-1:0]  mask_i,
  output logic             irq_o,
  output logic [IDX_W-1:0] idx_o
);
  logic [NSRC-1:0] pend;
  always_comb begin
    pend  = flag_i & mask_i & {NSRC{gie_i}};
    irq_o = |pend;
    if (pend[SRC_CMPA])      idx_o = IDX_W'(SRC_CMPA);
    else if (pend[SRC_CMPB]) idx_o = IDX_W'(SRC_CMPB);
    else                     idx_o = IDX_W'(SRC_OVF);
  end
endmodule

// File: rtl/tmr_irq_unit.sv
module tmr_irq_unit
  import tmr_irq_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] count_i,
  input  logic              ovf_i,
  input  logic              gie_i,
  input  logic              bus_we_i,
  input  logic [1:0]        bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic              ack_i,
  input  logic [IDX_W-1:0]  ack_idx_i,
  output logic              irq_o,
  output logic [IDX_W-1:0]  irq_idx_o
);
  logic [NSRC-1:0]              mask_q, flag, set, wclr, aclr;
  logic [NCMP-1:0]              cmp_we, match;
  logic [NCMP-1:0][DATA_W-1:0]  cmp;
  reg_sel_e                     sel;

  assign sel = reg_sel_e'(bus_addr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            mask_q <= '0;
    else if (bus_we_i && sel == REG_MASK)   mask_q <= bus_wdata_i[NSRC-1:0];
  end

  assign cmp_we = {bus_we_i && sel == REG_CMPB, bus_we_i && sel == REG_CMPA};

  tmr_cmp_bank #(.CNT_W(DATA_W), .NCMP(NCMP)) u_cmp (
    .clk_i(clk_i), .rst_ni(rst_ni), .count_i(count_i), .wr_en_i(cmp_we),
    .wdata_i(bus_wdata_i), .cmp_o(cmp), .match_o(match)
  );

  always_comb begin
    set           = '0;
    set[SRC_OVF]  = ovf_i;
    set[SRC_CMPA] = match[0];
    set[SRC_CMPB] = match[1];
    wclr = (bus_we_i && sel == REG_FLAG) ? bus_wdata_i[NSRC-1:0] : '0;
    aclr = ack_i ? (NSRC'(1) << ack_idx_i) : '0;  // code 3 shifts out
  end

  tmr_flag_reg #(.NSRC(NSRC)) u_flag (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(set), .wclr_i(wclr),
    .aclr_i(aclr), .flag_o(flag)
  );

  tmr_irq_arb u_arb (
    .gie_i(gie_i), .flag_i(flag), .mask_i(mask_q),
    .irq_o(irq_o), .idx_o(irq_idx_o)
  );

  always_comb begin
    unique case (sel)
      REG_MASK: bus_rdata_o = DATA_W'(mask_q);
      REG_FLAG: bus_rdata_o = DATA_W'(flag);
      REG_CMPA: bus_rdata_o = cmp[0];
      REG_CMPB: bus_rdata_o = cmp[1];
      default:  bus_rdata_o = '0;
    endcase
  end

  a_r1_match_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_i == cmp[0]) |=> flag[SRC_CMPA]);
  a_r1_match_b: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_i == cmp[1]) |=> flag[SRC_CMPB]);
  a_r2_ovf_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_i |=> flag[SRC_OVF]);
  a_r3_resv_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_addr_i < 2'd2) |-> bus_rdata_o[DATA_W-1:NSRC] == '0);
  a_r7_irq_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (gie_i && |(flag & mask_q)));
  a_r7_irq_raised: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gie_i && |(flag & mask_q)) |-> irq_o);
  a_r8_prio_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && irq_idx_o != IDX_W'(SRC_CMPA)) |-> !(flag[SRC_CMPA] && mask_q[SRC_CMPA]));
  a_r8_idx_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_idx_o != 2'd3);
endmodule

// File: tb/tmr_irq_unit_bench.sv
module tmr_irq_unit_bench;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic [7:0] count = '0, wdata = '0, rdata;
  logic       ovf = 0, gie = 0, we = 0, ack = 0, irq;
  logic [1:0] addr = '0, ack_idx = '0, irq_idx;
  int checks = 0, fails = 0;
  logic [2:0] m_mask = '0, m_flag = '0;
  logic [7:0] m_cmpa = '0, m_cmpb = '0;

  always #5 clk = ~clk;

  tmr_irq_unit u_tmr_irq_unit (
    .clk_i(clk), .rst_ni(rst_n), .count_i(count), .ovf_i(ovf), .gie_i(gie),
    .bus_we_i(we), .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .ack_i(ack), .ack_idx_i(ack_idx), .irq_o(irq), .irq_idx_o(irq_idx)
  );

  function automatic logic [7:0] exp_rd(input logic [1:0] a);
    case (a)
      2'd0: return {5'b0, m_mask};
      2'd1: return {5'b0, m_flag};
      2'd2: return m_cmpa;
      default: return m_cmpb;
    endcase
  endfunction

  function automatic logic [2:0] exp_irq(input logic g);
    logic [2:0] p = m_flag & m_mask & {3{g}};
    if (p[1]) return {1'b1, 2'd1};
    if (p[2]) return {1'b1, 2'd2};
    if (p[0]) return {1'b1, 2'd0};
    return 3'b000;
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(input logic w, input logic [1:0] a, input logic [7:0] d,
                     input logic [7:0] c, input logic o, input logic k,
                     input logic [1:0] ki, input logic g);
    logic [2:0] st, wc, ac, e;
    @(negedge clk);
    we = w; addr = a; wdata = d; count = c; ovf = o; ack = k; ack_idx = ki; gie = g;
    #1;
    e = exp_irq(g);
    chk(a == 2'd1 ? "R1/R2/R4/R5/R6 flag read" : "R3 register read", rdata, exp_rd(a));
    chk("R7 irq", {7'b0, irq}, {7'b0, e[2]});
    chk("R8 vector index", {6'b0, irq_idx}, {6'b0, e[1:0]});
    @(posedge clk);
    st = {c == m_cmpb, c == m_cmpa, o};
    wc = (w && a == 2'd1) ? d[2:0] : 3'b0;
    ac = (k && ki != 2'd3) ? 3'(1 << ki) : 3'b0;
    m_flag = st | (m_flag & ~wc & ~ac);
    if (w && a == 2'd0) m_mask = d[2:0];
    if (w && a == 2'd2) m_cmpa = d;
    if (w && a == 2'd3) m_cmpb = d;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int seed = 1234;
    void'($urandom(seed));
    count = 8'h55;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R9: reset values on all four registers
    for (int i = 0; i < 4; i++) begin
      addr = 2'(i); #1;
      chk("R9 reset value", rdata, 8'h00);
    end
    // enable all, match both channels at count 0 (R1, R8: A beats B)
    cyc(1, 2'd0, 8'hFF, 8'h55, 0, 0, 0, 1);          // R3: mask upper bits dropped
    cyc(0, 2'd0, 8'h00, 8'h00, 1, 0, 0, 1);
    cyc(0, 2'd1, 8'h00, 8'h55, 0, 0, 0, 1);          // R8 idx A
    // R6: ack A while A matches again
    cyc(0, 2'd1, 8'h00, 8'h00, 0, 1, 2'd1, 1);
    // R5: ack code 3 clears nothing
    cyc(0, 2'd1, 8'h00, 8'h55, 0, 1, 2'd3, 1);
    // R5: ack A clears A only, then R8 idx B
    cyc(0, 2'd1, 8'h00, 8'h55, 0, 1, 2'd1, 1);
    cyc(0, 2'd1, 8'h00, 8'h55, 0, 0, 0, 1);
    // R4: write zero keeps, write one clears B; R6 with overflow set
    cyc(1, 2'd1, 8'h00, 8'h55, 0, 0, 0, 1);
    cyc(1, 2'd1, 8'hFF, 8'h55, 1, 0, 0, 1);
    cyc(0, 2'd1, 8'h00, 8'h55, 0, 0, 0, 0);          // R7 gated by gie
    cyc(0, 2'd1, 8'h00, 8'h55, 0, 0, 0, 1);          // R8 idx overflow
    // R1: new compare value used on the following cycle
    cyc(1, 2'd2, 8'h40, 8'h40, 0, 0, 0, 1);
    cyc(0, 2'd1, 8'h00, 8'h40, 0, 0, 0, 1);
    cyc(0, 2'd1, 8'h00, 8'h55, 0, 0, 0, 1);
    for (int n = 0; n < 4000; n++) begin
      logic [7:0] c;
      logic [1:0] a;
      int r = $urandom_range(0, 3);
      c = (r == 0) ? m_cmpa : (r == 1) ? m_cmpb : 8'($urandom);
      a = 2'($urandom);
      cyc($urandom_range(0, 9) < 3, a, 8'($urandom), c,
          $urandom_range(0, 3) == 0, $urandom_range(0, 4) == 0,
          2'($urandom), $urandom_range(0, 9) < 8);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule